// File: doc/BRIEF.md
# DRAM Column Command and Data Window Scheduler

This block sits on the controller side of a double-data-rate DRAM interface. It takes read and write column commands through a valid/ready handshake and drives the command pins with the correct encoding. For every accepted command it opens the data window on the correct clock. Read windows open on the capture side and write windows on the drive side. Each data clock carries two beats, one on the rising half and one on the falling half, and a per-beat enable vector marks both. For writes the block also raises the strobe output enable, which includes a single preamble clock before the first data clock. A separate precharge request port is held back until the write-recovery time of the addressed bank has passed.

The data windows are placed from static configuration inputs: additive latency (0..4), CAS latency (3..6), write recovery (2..6 clocks) and burst length (4 or 8 beats, so 2 or 4 data clocks). The read latency is the sum of additive and CAS latency. The write latency is one clock less. A command is rejected with `cmd_ready` low if it would collide with a burst already in flight or would turn the bus around without an idle clock. Same-direction bursts that arrive exactly one burst duration apart stream with no gap.

Top module: `ddr_burst_sched`

## Requirements
- R1: While `rst_n` is low the pins are deselected ({cs_n,ras_n,cas_n,we_n} = 1111) and every data enable is low. When idle after reset the pins carry a NOP, 0111.
- R2: An accepted read appears on the pins in the clock after acceptance as {cs_n,ras_n,cas_n,we_n} = 0101, with the request's bank on `ddr_ba` and its column on `ddr_addr`. It appears for exactly one clock.
- R3: Take the clock in which the read is on the pins as cycle 0. `rd_capture_en` is 2'b11 from cycle AL+CL for 2 clocks (BL4) or 4 clocks (BL8), and 2'b00 around that window. `rd_last` is high only on the final window clock.
- R4: An accepted write appears on the pins in the clock after acceptance as 0100, with its bank and column.
- R5: A write's `wr_drive_en` is 2'b11 from cycle AL+CL-1 for 2 or 4 clocks. `wr_last` is high only on the final window clock.
- R6: `dqs_oe` rises one clock before the first write data clock, with `dqs_preamble` high in that clock only. `dqs_oe` stays high through the last data clock and drops in the clock after it. No drive enable is asserted past the last beat.
- R7: Same-direction bursts accepted exactly one burst duration apart (2 clocks for BL4, 4 for BL8) produce one unbroken data window. No preamble is inserted between them.
- R8: A column command whose data window would overlap a window in flight is refused (`cmd_ready` low). The pins carry no column command for it.
- R9: A command of the opposite direction to a window in flight is refused unless at least one clock with neither read nor write data separates the two windows.
- R10: An accepted precharge appears in the next clock as 0010 with its bank on `ddr_ba`.
- R11: A precharge to a bank that was written is refused until its pin clock is at least WL + burst clocks + WR clocks after that write's pin clock. A precharge to other banks is not delayed.
- R12: A column command takes priority: when one is accepted, `pre_ready` is low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_al | input | 3 | Additive latency, 0..4 |
| cfg_cl | input | 3 | CAS latency, 3..6 |
| cfg_wr | input | 3 | Write recovery clocks, 2..6 |
| cfg_bl8 | input | 1 | 1 = 8-beat bursts, 0 = 4-beat bursts |
| cmd_valid | input | 1 | Column command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | BANK_W | Target bank |
| cmd_col | input | COL_W | Starting column |
| cmd_ready | output | 1 | Column command can be accepted this clock |
| pre_valid | input | 1 | Precharge request |
| pre_bank | input | BANK_W | Bank to precharge |
| pre_ready | output | 1 | Precharge can be accepted this clock |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank address pins |
| ddr_addr | output | COL_W | Column address pins |
| rd_capture_en | output | 2 | Per-beat read capture enables (rising, falling half) |
| rd_last | output | 1 | Final clock of a read window |
| wr_drive_en | output | 2 | Per-beat write drive enables |
| wr_last | output | 1 | Final clock of a write window |
| dqs_oe | output | 1 | Write strobe output enable |
| dqs_preamble | output | 1 | Strobe is in its low preamble clock |

## Verification
The hardest states to reach are the narrow acceptance edges. A write must be refused three clocks after a BL4 read and accepted four clocks after it. A read must be refused one clock after a write and accepted two clocks after it. A precharge must be refused up to the exact clock where write recovery expires. The directed tasks issue commands at single-clock spacing, starting from a known acceptance clock. The recovery case retries the precharge every clock and compares the clock of the first acceptance with the value computed from WL, the burst clocks and WR. Seamless streaming is reached by spacing same-direction commands exactly one burst duration apart. The test then checks that the recorded enable history has no hole and no extra preamble.

// File: rtl/ddr_sched_pkg.sv
`timescale 1ns/1ps
// Shared encodings and helpers for the DRAM burst scheduler.
package ddr_sched_pkg;

    // Pin encoding {ras_n, cas_n, we_n}; chip select is low for all of these.
    typedef enum logic [2:0] {
        OP_NOP   = 3'b111,
        OP_READ  = 3'b101,
        OP_WRITE = 3'b100,
        OP_PRE   = 3'b010
    } ddr_op_e;

    // Number of data clocks a burst occupies for a given beats-per-clock rate.
    function automatic int burst_clocks(input logic bl8, input int beats_per_clk);
        return (bl8 ? 8 : 4) / beats_per_clk;
    endfunction

endpackage

// File: rtl/ddr_cmd_encoder.sv
`timescale 1ns/1ps
// Registers the command pins. Exactly one of issue_col / issue_pre may be
// high in a clock (the top guarantees it); otherwise a NOP is driven.
// Assumes: bank/column inputs are valid whenever an issue strobe is high.
module ddr_cmd_encoder
    import ddr_sched_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_col,
    input  logic              col_write,
    input  logic [BANK_W-1:0] col_bank,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              issue_pre,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [COL_W-1:0]  addr
);

    ddr_op_e op_next;

    // Pick the operation for the next clock.
    always_comb begin
        if (issue_col)      op_next = col_write ? OP_WRITE : OP_READ;
        else if (issue_pre) op_next = OP_PRE;
        else                op_next = OP_NOP;
    end

    // Register pins; reset deselects the device.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n                 <= 1'b1;
            {ras_n, cas_n, we_n} <= 3'b111;
            ba                   <= '0;
            addr                 <= '0;
        end else begin
            cs_n                 <= 1'b0;
            {ras_n, cas_n, we_n} <= op_next;
            if (issue_col) begin
                ba   <= col_bank;
                addr <= col_addr;
            end else if (issue_pre) begin
                ba   <= pre_bank;
                addr <= '0;
            end
        end
    end

endmodule

// File: rtl/ddr_data_window.sv
`timescale 1ns/1ps
// Future-occupancy timeline of the data bus. Bit k of each slot vector
// stands for the clock k cycles after the current one; bit 0 drives the
// outputs. An issued command marks its window relative to its pin clock.
// It also reports whether a read or a write issued now would collide with
// data already in flight or lack a one-clock turnaround gap.
// Assumes: DEPTH exceeds the largest read latency plus burst clocks.
module ddr_data_window #(
    parameter int DEPTH = 16,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_rd,
    input  logic             issue_wr,
    input  logic [LAT_W-1:0] rl,
    input  logic [LAT_W-1:0] wl,
    input  logic [LAT_W-1:0] nclk,
    output logic             rd_en,
    output logic             rd_last,
    output logic             wr_en,
    output logic             wr_last,
    output logic             wr_pre,
    output logic             rd_block,
    output logic             wr_block
);

    logic [DEPTH-1:0] rd_s, wr_s, rdl_s, wrl_s, pre_s;
    logic [DEPTH-1:0] rd_sh, wr_sh, rdl_sh, wrl_sh, pre_sh;
    logic [DEPTH-1:0] rd_win, wr_win, rd_lmk, wr_lmk, pre_mk, rd_guard, wr_guard;

    // Advance the timeline by one clock.
    always_comb begin
        rd_sh  = rd_s  >> 1;
        wr_sh  = wr_s  >> 1;
        rdl_sh = rdl_s >> 1;
        wrl_sh = wrl_s >> 1;
        pre_sh = pre_s >> 1;
    end

    // Build window, last-clock, preamble and guard masks from the latencies.
    always_comb begin
        int rl_i, wl_i, n_i;
        rl_i = int'(rl);
        wl_i = int'(wl);
        n_i  = int'(nclk);
        for (int k = 0; k < DEPTH; k++) begin
            rd_win[k]   = (k >= rl_i) && (k < rl_i + n_i);
            wr_win[k]   = (k >= wl_i) && (k < wl_i + n_i);
            rd_lmk[k]   = (k == rl_i + n_i - 1);
            wr_lmk[k]   = (k == wl_i + n_i - 1);
            pre_mk[k]   = (k == wl_i - 1);
            rd_guard[k] = (k == rl_i - 1) || (k == rl_i + n_i);
            wr_guard[k] = (k == wl_i - 1) || (k == wl_i + n_i);
        end
    end

    // Collision and turnaround tests against data already scheduled.
    always_comb begin
        rd_block = (|((rd_sh | wr_sh) & rd_win)) || (|(wr_sh & rd_guard));
        wr_block = (|((rd_sh | wr_sh) & wr_win)) || (|(rd_sh & wr_guard));
    end

    // Shift the timeline and merge newly issued windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_s  <= '0;
            wr_s  <= '0;
            rdl_s <= '0;
            wrl_s <= '0;
            pre_s <= '0;
        end else begin
            rd_s  <= rd_sh  | (issue_rd ? rd_win : '0);
            rdl_s <= rdl_sh | (issue_rd ? rd_lmk : '0);
            wr_s  <= wr_sh  | (issue_wr ? wr_win : '0);
            wrl_s <= wrl_sh | (issue_wr ? wr_lmk : '0);
            pre_s <= pre_sh | (issue_wr ? pre_mk : '0);
        end
    end

    // Current-clock view; a preamble under streaming data is suppressed.
    assign rd_en   = rd_s[0];
    assign rd_last = rdl_s[0];
    assign wr_en   = wr_s[0];
    assign wr_last = wrl_s[0];
    assign wr_pre  = pre_s[0] & ~wr_s[0];

endmodule

// File: rtl/ddr_wr_recovery.sv
`timescale 1ns/1ps
// Per-bank write-recovery lockout counters. A write loads its bank's
// counter so that it reaches zero in the last clock before a precharge
// pin clock becomes legal. pre_ok reports the addressed bank's state.
// Assumes: load_val already includes WL, burst clocks and WR, minus one.
module ddr_wr_recovery #(
    parameter int BANK_W = 3,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              pre_ok
);

    localparam int BANKS = 1 << BANK_W;

    logic [CNT_W-1:0] cnt [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Load on a write to this bank, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   cnt[b] <= '0;
            else if (wr_go && (wr_bank == BANK_W'(b)))    cnt[b] <= load_val;
            else if (cnt[b] != '0)                        cnt[b] <= cnt[b] - CNT_W'(1);
        end
    end

    assign pre_ok = (cnt[pre_bank] == '0);

endmodule

// File: rtl/ddr_burst_sched.sv
`timescale 1ns/1ps
// Top of the burst scheduler. Derives read/write latency and burst clocks
// from the configuration inputs. It accepts column commands that fit the
// data-bus timeline and gates precharges on write recovery. The command
// pins and the data enables are all registered.
// Assumes: configuration is static while any burst or lockout is pending.
module ddr_burst_sched
    import ddr_sched_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int BEATS  = 2,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_al,
    input  logic [2:0]        cfg_cl,
    input  logic [2:0]        cfg_wr,
    input  logic              cfg_bl8,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ready,
    input  logic              pre_valid,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              pre_ready,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BANK_W-1:0] ddr_ba,
    output logic [COL_W-1:0]  ddr_addr,
    output logic [BEATS-1:0]  rd_capture_en,
    output logic              rd_last,
    output logic [BEATS-1:0]  wr_drive_en,
    output logic              wr_last,
    output logic              dqs_oe,
    output logic              dqs_preamble
);

    localparam int LAT_W = $clog2(DEPTH) + 1;
    localparam int CNT_W = LAT_W + 1;

    logic [LAT_W-1:0] rl, wl, nclk;
    logic [CNT_W-1:0] rec_load;
    logic             rd_block, wr_block, pre_ok;
    logic             col_go, pre_go;
    logic             rd_en, wr_en, wr_pre;

    // Latency and burst-length derivation from configuration.
    always_comb begin
        rl       = LAT_W'(cfg_al) + LAT_W'(cfg_cl);
        wl       = rl - LAT_W'(1);
        nclk     = LAT_W'(burst_clocks(cfg_bl8, BEATS));
        rec_load = CNT_W'(wl) + CNT_W'(nclk) + CNT_W'(cfg_wr) - CNT_W'(1);
    end

    // Handshakes: column commands first, precharge only in a free clock.
    always_comb begin
        cmd_ready = rst_n && (cmd_write ? !wr_block : !rd_block);
        col_go    = cmd_valid && cmd_ready;
        pre_ready = rst_n && !col_go && pre_ok;
        pre_go    = pre_valid && pre_ready;
    end

    ddr_cmd_encoder #(.BANK_W(BANK_W), .COL_W(COL_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_col (col_go),
        .col_write (cmd_write),
        .col_bank  (cmd_bank),
        .col_addr  (cmd_col),
        .issue_pre (pre_go),
        .pre_bank  (pre_bank),
        .cs_n      (ddr_cs_n),
        .ras_n     (ddr_ras_n),
        .cas_n     (ddr_cas_n),
        .we_n      (ddr_we_n),
        .ba        (ddr_ba),
        .addr      (ddr_addr)
    );

    ddr_data_window #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_rd (col_go && !cmd_write),
        .issue_wr (col_go && cmd_write),
        .rl       (rl),
        .wl       (wl),
        .nclk     (nclk),
        .rd_en    (rd_en),
        .rd_last  (rd_last),
        .wr_en    (wr_en),
        .wr_last  (wr_last),
        .wr_pre   (wr_pre),
        .rd_block (rd_block),
        .wr_block (wr_block)
    );

    ddr_wr_recovery #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (col_go && cmd_write),
        .wr_bank  (cmd_bank),
        .load_val (rec_load),
        .pre_bank (pre_bank),
        .pre_ok   (pre_ok)
    );

    // Fan each data clock out to its per-beat enables; strobe covers preamble.
    always_comb begin
        rd_capture_en = {BEATS{rd_en}};
        wr_drive_en   = {BEATS{wr_en}};
        dqs_preamble  = wr_pre;
        dqs_oe        = wr_en | wr_pre;
    end

endmodule

// File: rtl/ddr_burst_sched_checker.sv
`timescale 1ns/1ps
// Protocol checker for ddr_burst_sched, bound to every instance.
module ddr_burst_sched_checker #(
    parameter int BANK_W = 3,
    parameter int BEATS  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_write,
    input logic             pre_valid,
    input logic             pre_ready,
    input logic             ddr_cs_n,
    input logic             ddr_ras_n,
    input logic             ddr_cas_n,
    input logic             ddr_we_n,
    input logic [BEATS-1:0] rd_capture_en,
    input logic             rd_last,
    input logic [BEATS-1:0] wr_drive_en,
    input logic             wr_last,
    input logic             dqs_oe,
    input logic             dqs_preamble
);

    // R1: reset deselects the device in the following clock.
    a_r1_reset_deselect: assert property (@(posedge clk) !rst_n |=> ddr_cs_n);

    // R2: accepted read shows read encoding next clock.
    a_r2_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_write) |=>
        (!ddr_cs_n && ddr_ras_n && !ddr_cas_n && ddr_we_n));

    // R4: accepted write shows write encoding next clock.
    a_r4_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_write) |=>
        (!ddr_cs_n && ddr_ras_n && !ddr_cas_n && !ddr_we_n));

    // R3: the final read clock carries beat enables.
    a_r3_last_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (rd_capture_en != '0));

    // R5: the final write clock carries beat enables.
    a_r5_last_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |-> (wr_drive_en != '0));

    // R6: a preamble clock is followed by write data; strobe covers data.
    a_r6_preamble_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_preamble |=> (wr_drive_en != '0));
    a_r6_strobe_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_drive_en != '0) |-> dqs_oe);

    // R8: a refused column command with no precharge leaves a NOP.
    a_r8_refused_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !(pre_valid && pre_ready)) |=>
        (ddr_ras_n && ddr_cas_n && ddr_we_n));

    // R9: never read and write data in the same or adjacent clocks.
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_capture_en != '0) && (wr_drive_en != '0)));
    a_r9_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_drive_en != '0) |=> (rd_capture_en == '0));
    a_r9_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_capture_en != '0) |=> (wr_drive_en == '0));

    // R10: accepted precharge shows precharge encoding next clock.
    a_r10_pre_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_valid && pre_ready) |=>
        (!ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n));

    // R12: never two commands accepted in one clock.
    a_r12_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready && pre_valid && pre_ready));

endmodule

bind ddr_burst_sched ddr_burst_sched_checker #(.BANK_W(BANK_W), .BEATS(BEATS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_write     (cmd_write),
    .pre_valid     (pre_valid),
    .pre_ready     (pre_ready),
    .ddr_cs_n      (ddr_cs_n),
    .ddr_ras_n     (ddr_ras_n),
    .ddr_cas_n     (ddr_cas_n),
    .ddr_we_n      (ddr_we_n),
    .rd_capture_en (rd_capture_en),
    .rd_last       (rd_last),
    .wr_drive_en   (wr_drive_en),
    .wr_last       (wr_last),
    .dqs_oe        (dqs_oe),
    .dqs_preamble  (dqs_preamble)
);

// File: tb/ddr_burst_sched_bench.sv
`timescale 1ns/1ps
// Directed bench: a monitor records every clock's outputs by index, and
// each scenario task issues commands and checks the recorded history.
module ddr_burst_sched_bench;

    localparam int HN = 2048;
    // History channels
    localparam int S_RD = 0, S_WR = 1, S_RDL = 2, S_WRL = 3, S_OE = 4,
                   S_PRE = 5, S_CMD = 6, S_BA = 7, S_ADDR = 8;
    // {cs_n,ras_n,cas_n,we_n} codes
    localparam int C_DESEL = 15, C_NOP = 7, C_RD = 5, C_WR = 4, C_PRE = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_al, cfg_cl, cfg_wr;
    logic       cfg_bl8;
    logic       cmd_valid, cmd_write;
    logic [2:0] cmd_bank;
    logic [9:0] cmd_col;
    logic       cmd_ready;
    logic       pre_valid;
    logic [2:0] pre_bank;
    logic       pre_ready;
    logic       ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0] ddr_ba;
    logic [9:0] ddr_addr;
    logic [1:0] rd_capture_en, wr_drive_en;
    logic       rd_last, wr_last, dqs_oe, dqs_preamble;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int hist [9][HN];
    bit done = 0;

    always #2.5 clk = ~clk;

    ddr_burst_sched u_ddr_burst_sched (
        .clk(clk), .rst_n(rst_n),
        .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_wr(cfg_wr), .cfg_bl8(cfg_bl8),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_ready(cmd_ready),
        .pre_valid(pre_valid), .pre_bank(pre_bank), .pre_ready(pre_ready),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
        .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr),
        .rd_capture_en(rd_capture_en), .rd_last(rd_last),
        .wr_drive_en(wr_drive_en), .wr_last(wr_last),
        .dqs_oe(dqs_oe), .dqs_preamble(dqs_preamble)
    );

    // Record outputs mid-cycle; index = clocks since start.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc < HN) begin
            hist[S_RD][cyc]   = int'(rd_capture_en);
            hist[S_WR][cyc]   = int'(wr_drive_en);
            hist[S_RDL][cyc]  = int'(rd_last);
            hist[S_WRL][cyc]  = int'(wr_last);
            hist[S_OE][cyc]   = int'(dqs_oe);
            hist[S_PRE][cyc]  = int'(dqs_preamble);
            hist[S_CMD][cyc]  = int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n});
            hist[S_BA][cyc]   = int'(ddr_ba);
            hist[S_ADDR][cyc] = int'(ddr_addr);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One check: every recorded clock in [from,to] of a channel equals exp.
    task automatic chk_range(input string req, input string what, input int sel,
                             input int from, input int to, input int exp);
        int bad = -1;
        int got = 0;
        for (int i = from; i <= to; i++) begin
            if (hist[sel][i] != exp && bad < 0) begin
                bad = i;
                got = hist[sel][i];
            end
        end
        n_chk++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s %s at clock %0d: actual %0d expected %0d", req, what, bad, got, exp);
        end
    endtask

    // Offer a column command for one clock (called just after a falling edge).
    task automatic col_cmd(input bit wr, input int bank, input int col, output bit ok, output int acc);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_bank  = bank[2:0];
        cmd_col   = col[9:0];
        #1;
        ok  = cmd_ready;
        acc = cyc + 1;
        @(negedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    // Offer a precharge for one clock.
    task automatic pre_cmd(input int bank, output bit ok, output int acc);
        pre_valid = 1'b1;
        pre_bank  = bank[2:0];
        #1;
        ok  = pre_ready;
        acc = cyc + 1;
        @(negedge clk);
        #1;
        pre_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_cfg(input int al, input int cl, input int wr, input bit bl8);
        cfg_al = al[2:0]; cfg_cl = cl[2:0]; cfg_wr = wr[2:0]; cfg_bl8 = bl8;
    endtask

    // R1: deselect during reset, NOP once idle.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk("R1", "pins in reset", int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), C_DESEL);
        chk("R1", "data enables in reset", int'({rd_capture_en, wr_drive_en, dqs_oe}), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1", "idle NOP", hist[S_CMD][cyc], C_NOP);
        chk("R1", "idle strobe", hist[S_OE][cyc], 0);
    endtask

    // R2, R3: single BL4 read with AL=2, CL=3.
    task automatic t_read_bl4();
        bit ok; int a;
        set_cfg(2, 3, 3, 1'b0);
        col_cmd(1'b0, 3, 'h155, ok, a);
        idle(12);
        chk("R2", "read accepted", int'(ok), 1);
        chk("R2", "read encoding", hist[S_CMD][a], C_RD);
        chk("R2", "read bank", hist[S_BA][a], 3);
        chk("R2", "read column", hist[S_ADDR][a], 'h155);
        chk("R2", "single clock command", hist[S_CMD][a+1], C_NOP);
        chk_range("R3", "no capture before RL", S_RD, a, a+4, 0);
        chk_range("R3", "capture window", S_RD, a+5, a+6, 3);
        chk_range("R3", "no capture after", S_RD, a+7, a+9, 0);
        chk("R3", "last flag", hist[S_RDL][a+6], 1);
        chk("R3", "not last on first", hist[S_RDL][a+5], 0);
    endtask

    // R4, R5, R6: single BL8 write with AL=2, CL=3 (WL=4).
    task automatic t_write_bl8();
        bit ok; int a;
        set_cfg(2, 3, 3, 1'b1);
        col_cmd(1'b1, 5, 'h0A8, ok, a);
        idle(16);
        chk("R4", "write accepted", int'(ok), 1);
        chk("R4", "write encoding", hist[S_CMD][a], C_WR);
        chk("R4", "write bank", hist[S_BA][a], 5);
        chk_range("R5", "no drive before WL", S_WR, a, a+3, 0);
        chk_range("R5", "drive window", S_WR, a+4, a+7, 3);
        chk("R5", "write last flag", hist[S_WRL][a+7], 1);
        chk("R5", "not last early", hist[S_WRL][a+6], 0);
        chk_range("R6", "no drive after burst", S_WR, a+8, a+11, 0);
        chk("R6", "preamble clock", hist[S_PRE][a+3], 1);
        chk_range("R6", "no preamble in data", S_PRE, a+4, a+7, 0);
        chk_range("R6", "strobe enable span", S_OE, a+3, a+7, 1);
        chk("R6", "strobe off before", hist[S_OE][a+2], 0);
        chk("R6", "strobe off after", hist[S_OE][a+8], 0);
    endtask

    // R7, R8: streaming reads (BL4) and writes (BL8), with a refused overlap.
    task automatic t_seamless();
        bit ok; int a, b, c, r;
        set_cfg(2, 3, 3, 1'b0);
        col_cmd(1'b0, 1, 'h10, ok, a);
        chk("R7", "first read accepted", int'(ok), 1);
        col_cmd(1'b0, 2, 'h20, ok, r);
        chk("R8", "overlapping read refused", int'(ok), 0);
        col_cmd(1'b0, 2, 'h20, ok, b);
        chk("R7", "second read one burst later", int'(ok), 1);
        idle(1);
        col_cmd(1'b0, 1, 'h30, ok, c);
        chk("R7", "third read accepted", int'(ok), 1);
        idle(14);
        chk("R8", "no command for refused read", hist[S_CMD][r], C_NOP);
        chk("R7", "stream spacing", c - a, 4);
        chk_range("R7", "read stream unbroken", S_RD, a+5, a+10, 3);
        chk("R7", "nothing before stream", hist[S_RD][a+4], 0);
        chk("R7", "nothing after stream", hist[S_RD][a+11], 0);
        chk("R7", "middle burst last", hist[S_RDL][a+8], 1);
        chk("R7", "no last inside burst", hist[S_RDL][a+7], 0);

        set_cfg(2, 3, 3, 1'b1);
        col_cmd(1'b1, 0, 'h40, ok, a);
        idle(3);
        col_cmd(1'b1, 4, 'h48, ok, b);
        chk("R7", "second write one burst later", int'(ok), 1);
        idle(16);
        chk_range("R7", "write stream unbroken", S_WR, a+4, a+11, 3);
        chk("R7", "single preamble", hist[S_PRE][a+3], 1);
        chk_range("R7", "no mid-stream preamble", S_PRE, a+4, a+11, 0);
        chk_range("R7", "strobe held", S_OE, a+3, a+11, 1);
    endtask

    // R9: turnaround gaps in both directions (BL4, RL=5, WL=4).
    task automatic t_turnaround();
        bit ok; int a, w, b, r;
        set_cfg(2, 3, 3, 1'b0);
        col_cmd(1'b0, 1, 'h00, ok, a);
        idle(2);
        col_cmd(1'b1, 1, 'h08, ok, w);
        chk("R9", "write three clocks after read refused", int'(ok), 0);
        col_cmd(1'b1, 1, 'h08, ok, w);
        chk("R9", "write four clocks after read accepted", int'(ok), 1);
        idle(12);
        chk("R9", "write acceptance offset", w - a, 4);
        chk_range("R9", "read data", S_RD, a+5, a+6, 3);
        chk("R9", "idle gap no read", hist[S_RD][a+7], 0);
        chk("R9", "idle gap no write", hist[S_WR][a+7], 0);
        chk_range("R9", "write data after gap", S_WR, a+8, a+9, 3);

        col_cmd(1'b1, 2, 'h10, ok, b);
        col_cmd(1'b0, 2, 'h18, ok, r);
        chk("R9", "read one clock after write refused", int'(ok), 0);
        col_cmd(1'b0, 2, 'h18, ok, r);
        chk("R9", "read two clocks after write accepted", int'(ok), 1);
        idle(12);
        chk_range("R9", "write then gap", S_WR, b+4, b+5, 3);
        chk("R9", "gap clock empty", hist[S_RD][b+6] + hist[S_WR][b+6], 0);
        chk_range("R9", "read after gap", S_RD, b+7, b+8, 3);
    endtask

    // R10, R11: write recovery lockout and an unaffected bank.
    task automatic t_recovery();
        bit ok; int a, p, q;
        set_cfg(2, 3, 3, 1'b0);
        col_cmd(1'b1, 2, 'h3C, ok, a);
        pre_cmd(6, ok, q);
        chk("R11", "other bank not delayed", int'(ok), 1);
        p = -1;
        for (int t = 0; t < 40; t++) begin
            pre_cmd(2, ok, p);
            if (ok) break;
        end
        idle(4);
        chk("R10", "precharge encoding", hist[S_CMD][q], C_PRE);
        chk("R10", "precharge bank", hist[S_BA][q], 6);
        // WL 4 + burst 2 + WR 3 clocks after the write's pin clock
        chk("R11", "first legal precharge clock", p - a, 9);
        chk("R11", "locked precharge encoding", hist[S_CMD][p], C_PRE);
        chk("R11", "locked precharge bank", hist[S_BA][p], 2);
        chk_range("R11", "no early precharge", S_CMD, q+1, p-1, C_NOP);
    endtask

    // R12: column command and precharge offered together.
    task automatic t_priority();
        bit okc, okp; int a;
        set_cfg(2, 3, 3, 1'b0);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 3'd7; cmd_col = 10'h2A;
        pre_valid = 1'b1; pre_bank = 3'd7;
        #1;
        okc = cmd_ready;
        okp = pre_ready;
        a = cyc + 1;
        @(negedge clk);
        #1;
        cmd_valid = 1'b0;
        pre_valid = 1'b0;
        idle(10);
        chk("R12", "column accepted", int'(okc), 1);
        chk("R12", "precharge held off", int'(okp), 0);
        chk("R12", "pins carry read", hist[S_CMD][a], C_RD);
    endtask

    // R3, R5, R6: latency extremes (WL=2 minimum, RL=10 maximum).
    task automatic t_latency_edges();
        bit ok; int a;
        set_cfg(0, 3, 2, 1'b0);
        col_cmd(1'b1, 0, 'h04, ok, a);
        idle(10);
        chk("R6", "min WL preamble", hist[S_PRE][a+1], 1);
        chk_range("R5", "min WL drive", S_WR, a+2, a+3, 3);
        chk("R5", "min WL nothing after", hist[S_WR][a+4], 0);
        set_cfg(4, 6, 6, 1'b1);
        col_cmd(1'b0, 1, 'h08, ok, a);
        idle(18);
        chk_range("R3", "max RL nothing early", S_RD, a, a+9, 0);
        chk_range("R3", "max RL window", S_RD, a+10, a+13, 3);
        chk("R3", "max RL last", hist[S_RDL][a+13], 1);
        chk("R3", "max RL nothing after", hist[S_RD][a+14], 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_bank = '0; cmd_col = '0;
        pre_valid = 1'b0; pre_bank = '0;
        set_cfg(2, 3, 3, 1'b0);
        t_reset();
        t_read_bl4();
        t_write_bl8();
        t_seamless();
        t_turnaround();
        t_recovery();
        t_priority();
        t_latency_edges();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule